// File: doc/BRIEF.md
# Three-Wire RTC Serial Master

This block runs one transaction at a time on a bit-serial link to a clock and parameter-memory chip. The link has three lines: a serial clock that rests high, an active-low chip enable, and one data line that the block either drives or releases. The data line appears at the ports as separate out, output-enable and in signals. A host hands over a 16-bit command word and a write byte. The block pulls enable low and shifts out one or two command bytes. It then either shifts out the write byte or releases the data line and shifts in a one-byte reply. Finally it raises enable and pulses `done_o`.

The request side is valid/ready. A request is taken in the cycle where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is high only while the link is idle, so the host must hold its request until it sees ready. A request offered while busy is not queued and leaves no trace. The completion side is plain status: `done_o` is a one-cycle pulse and cannot be stalled, and `rdata_o` keeps its value until the next read shifts into it.

How the command bits are encoded is up to the caller, apart from the rules the block decodes for length and direction. The speed of the serial clock is set by `div_i`, which gives each half-period in system clocks.

Top module: `rtc_wire_master`

## Requirements
- R1: After reset and between transactions, `ser_en_n_o`=1, `ser_clk_o`=1, `ser_dat_oe_o`=1 and `req_ready_o`=1. After reset, `done_o`=0 and `rdata_o`=0.
- R2: A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both 1, and `ser_en_n_o` is 0 from the next cycle. `req_ready_o` stays 0 until the transaction has ended, and a request offered during that time starts nothing and changes nothing.
- R3: Every byte goes out most significant bit first, as 8 clock pulses. Each bit is placed on `ser_dat_o` while `ser_clk_o` is low, and the chip latches it on the rising edge that follows.
- R4: Bits [1:0] of the last command byte always go out as 0 then 1, whatever those bits of `req_cmd_i` hold.
- R5: If `req_cmd_i[15:8]` is nonzero, two command bytes are sent: bits [15:8] first, then bits [7:0], and bit 15 is the read flag. If it is zero, only bits [7:0] are sent and bit 7 is the read flag.
- R6: When the read flag is 0, the `req_wdata_i` byte follows the command bytes as 8 more driven bits.
- R7: When the read flag is 1, `ser_dat_oe_o` is 0 for the 8 pulses that follow the command bytes. `ser_dat_i` is sampled at the end of each high half-period and shifted into the LSB of `rdata_o`.
- R8: After the last high half-period, `ser_en_n_o` returns to 1 and `ser_dat_oe_o` to 1, and `done_o` is 1 for exactly one cycle. A write transaction leaves `rdata_o` unchanged.
- R9: Each half-period of `ser_clk_o`, and the stretch from enable falling to the first clock fall, lasts H system clocks. H is `div_i` taken when the request is accepted, or 1 if that value is 0. Later changes to `div_i` do not affect the running transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Half-period length in system clocks (0 counts as 1) |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Link idle, request can be taken |
| req_cmd_i | input | 2*BYTE_W | Command word; upper byte zero means a one-byte command |
| req_wdata_i | input | BYTE_W | Byte to send on write transactions |
| done_o | output | 1 | One-cycle pulse when a transaction ends |
| rdata_o | output | BYTE_W | Last byte received |
| ser_clk_o | output | 1 | Serial clock, high at rest |
| ser_en_n_o | output | 1 | Chip enable, active low |
| ser_dat_o | output | 1 | Data line, driven value |
| ser_dat_oe_o | output | 1 | Data line output enable |
| ser_dat_i | input | 1 | Data line, sampled value |

## Verification
The bench builds the block with its default 8-bit byte and 8-bit divider. With these values, all 256 one-byte commands can be run at the shortest half-period, covering both directions and every value of the two forced bits. Two-byte commands use a spread of upper bytes with and without bit 15, at divider settings 0, 2 and 3, so both the zero-means-one rule and multi-cycle half-periods are measured. A bench-side chip model captures bits on rising edges and serves the reply byte, so the expected frames and reply bytes are worked out in the bench from the command word alone.

// File: rtl/rtc_wire_pkg.sv
package rtc_wire_pkg;
  typedef enum logic [1:0] {
    LNK_IDLE = 2'd0,
    LNK_LEAD = 2'd1,
    LNK_LOW  = 2'd2,
    LNK_HIGH = 2'd3
  } link_st_e;
endpackage

// File: rtl/rtc_cmd_decode.sv
module rtc_cmd_decode #(
  parameter int BYTE_W = 8,
  localparam int FRAME_W = 3 * BYTE_W,
  localparam int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic [2*BYTE_W-1:0] cmd_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  output logic [FRAME_W-1:0]  frame_o,
  output logic [CNT_W-1:0]    cmd_bits_o,
  output logic [CNT_W-1:0]    tot_bits_o,
  output logic                is_read_o
);
  logic [BYTE_W-1:0] upper, last_cmd;
  logic              two_byte;

  always_comb begin
    upper    = cmd_i[2*BYTE_W-1:BYTE_W];
    last_cmd = {cmd_i[BYTE_W-1:2], 2'b01};
    two_byte = |upper;
    if (two_byte) begin
      frame_o    = {upper, last_cmd, wdata_i};
      is_read_o  = upper[BYTE_W-1];
      cmd_bits_o = CNT_W'(2 * BYTE_W);
    end else begin
      frame_o    = {last_cmd, wdata_i, {BYTE_W{1'b0}}};
      is_read_o  = last_cmd[BYTE_W-1];
      cmd_bits_o = CNT_W'(BYTE_W);
    end
    tot_bits_o = cmd_bits_o + CNT_W'(BYTE_W);
  end
endmodule

// File: rtl/rtc_half_timer.sv
module rtc_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt;

  assign tick_o = run_i && (cnt == half_i - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart_i || tick_o || !run_i) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/rtc_link_fsm.sv
module rtc_link_fsm
  import rtc_wire_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 8,
  localparam int FRAME_W = 3 * BYTE_W,
  localparam int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   cmd_bits_i,
  input  logic [CNT_W-1:0]   tot_bits_i,
  input  logic               is_read_i,
  input  logic               tick_i,
  input  logic               ser_dat_i,
  output logic               accept_o,
  output logic               running_o,
  output logic [DIV_W-1:0]   half_o,
  output logic               req_ready_o,
  output logic               done_o,
  output logic [BYTE_W-1:0]  rdata_o,
  output logic               ser_clk_o,
  output logic               ser_en_n_o,
  output logic               ser_dat_o,
  output logic               ser_dat_oe_o
);
  link_st_e           st;
  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   bit_idx, cmd_bits_q, tot_bits_q;
  logic               rd_q, in_reply, shifting;

  assign req_ready_o = (st == LNK_IDLE);
  assign accept_o    = req_ready_o && req_valid_i;
  assign running_o   = !req_ready_o;
  assign shifting    = (st == LNK_LOW) || (st == LNK_HIGH);
  assign in_reply    = rd_q && (bit_idx >= cmd_bits_q);

  assign ser_en_n_o   = req_ready_o;
  assign ser_clk_o    = (st != LNK_LOW);
  assign ser_dat_oe_o = !(shifting && in_reply);
  assign ser_dat_o    = ser_dat_oe_o && !req_ready_o && frame_q[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= LNK_IDLE;
      frame_q    <= '0;
      bit_idx    <= '0;
      cmd_bits_q <= '0;
      tot_bits_q <= '0;
      rd_q       <= 1'b0;
      half_o     <= DIV_W'(1);
      done_o     <= 1'b0;
      rdata_o    <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        LNK_IDLE: begin
          if (req_valid_i) begin
            st         <= LNK_LEAD;
            frame_q    <= frame_i;
            cmd_bits_q <= cmd_bits_i;
            tot_bits_q <= tot_bits_i;
            rd_q       <= is_read_i;
            bit_idx    <= '0;
            half_o     <= (div_i == '0) ? DIV_W'(1) : div_i;
          end
        end
        LNK_LEAD: if (tick_i) st <= LNK_LOW;
        LNK_LOW:  if (tick_i) st <= LNK_HIGH;
        LNK_HIGH: begin
          if (tick_i) begin
            if (in_reply) rdata_o <= {rdata_o[BYTE_W-2:0], ser_dat_i};
            frame_q <= frame_q << 1;
            if (bit_idx == tot_bits_q - CNT_W'(1)) begin
              st     <= LNK_IDLE;
              done_o <= 1'b1;
            end else begin
              bit_idx <= bit_idx + CNT_W'(1);
              st      <= LNK_LOW;
            end
          end
        end
        default: st <= LNK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rtc_wire_master.sv
module rtc_wire_master #(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_W-1:0]    div_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [2*BYTE_W-1:0] req_cmd_i,
  input  logic [BYTE_W-1:0]   req_wdata_i,
  output logic                done_o,
  output logic [BYTE_W-1:0]   rdata_o,
  output logic                ser_clk_o,
  output logic                ser_en_n_o,
  output logic                ser_dat_o,
  output logic                ser_dat_oe_o,
  input  logic                ser_dat_i
);
  localparam int FRAME_W = 3 * BYTE_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   cmd_bits, tot_bits;
  logic               is_read, tick, accept, running;
  logic [DIV_W-1:0]   half;

  rtc_cmd_decode #(.BYTE_W(BYTE_W)) u_dec (
    .cmd_i(req_cmd_i), .wdata_i(req_wdata_i), .frame_o(frame),
    .cmd_bits_o(cmd_bits), .tot_bits_o(tot_bits), .is_read_o(is_read)
  );

  rtc_half_timer #(.DIV_W(DIV_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart_i(accept), .run_i(running),
    .half_i(half), .tick_o(tick)
  );

  rtc_link_fsm #(.BYTE_W(BYTE_W), .DIV_W(DIV_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .div_i(div_i),
    .frame_i(frame), .cmd_bits_i(cmd_bits), .tot_bits_i(tot_bits),
    .is_read_i(is_read), .tick_i(tick), .ser_dat_i(ser_dat_i),
    .accept_o(accept), .running_o(running), .half_o(half),
    .req_ready_o(req_ready_o), .done_o(done_o), .rdata_o(rdata_o),
    .ser_clk_o(ser_clk_o), .ser_en_n_o(ser_en_n_o),
    .ser_dat_o(ser_dat_o), .ser_dat_oe_o(ser_dat_oe_o)
  );
endmodule

// File: rtl/rtc_wire_master_chk.sv
module rtc_wire_master_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              done_o,
  input logic [BYTE_W-1:0] rdata_o,
  input logic              ser_clk_o,
  input logic              ser_en_n_o,
  input logic              ser_dat_oe_o
);
  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en_n_o |-> (ser_clk_o && ser_dat_oe_o && req_ready_o));
  // R2
  accept_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> !ser_en_n_o);
  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en_n_o |-> !req_ready_o);
  // R7
  release_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_dat_oe_o |-> (!ser_en_n_o && !ser_clk_o) || (!ser_en_n_o && ser_clk_o));
  // R3
  clk_low_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_clk_o |-> !ser_en_n_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ser_en_n_o && ser_dat_oe_o && $past(!ser_en_n_o)));
  // R8
  rdata_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en_n_o && $past(ser_en_n_o)) |-> $stable(rdata_o));
endmodule

bind rtc_wire_master rtc_wire_master_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/rtc_wire_master_tb.sv
module rtc_wire_master_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_i = 8'd1;
  logic       req_valid_i = 1'b0;
  logic       req_ready_o;
  logic [15:0] req_cmd_i = '0;
  logic [7:0] req_wdata_i = '0;
  logic       done_o;
  logic [7:0] rdata_o;
  logic       ser_clk_o, ser_en_n_o, ser_dat_o, ser_dat_oe_o;
  logic       ser_dat_i = 1'b0;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  rtc_wire_master u_dut (.*);

  // bench-side chip model, sampled away from the active edge
  logic [23:0] cap;
  int ncap, nrel, rises, lowlen, badlow, leadlen, lead_seen;
  int exp_cmdb, exp_h;
  logic [7:0] reply;
  logic prev_clk = 1'b1;

  task automatic mon_clear();
    cap = '0; ncap = 0; nrel = 0; rises = 0; lowlen = 0; badlow = 0;
    leadlen = 0; lead_seen = 0; ser_dat_i = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!ser_en_n_o) begin
      if (ser_clk_o && !lead_seen) leadlen++;
      if (!ser_clk_o) begin
        lead_seen = 1;
        lowlen++;
      end
      if (!prev_clk && ser_clk_o) begin
        rises++;
        if (lowlen != exp_h) badlow++;
        lowlen = 0;
        if (ser_dat_oe_o) begin
          cap = {cap[22:0], ser_dat_o};
          ncap++;
        end else begin
          nrel++;
        end
        if (rises > exp_cmdb && rises <= exp_cmdb + 8)
          ser_dat_i = reply[exp_cmdb + 8 - rises];
        else
          ser_dat_i = 1'b0;
      end
    end
    prev_clk = ser_clk_o;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  logic [7:0] last_rd = 8'h00;

  task automatic run_txn(input logic [15:0] cmd, input logic [7:0] wd,
                         input logic [7:0] rep, input logic [7:0] dv,
                         input bit poke);
    logic [7:0] lo;
    logic [23:0] ef;
    bit two, rd;
    int nb, guard;
    lo  = {cmd[7:2], 2'b01};
    two = (cmd[15:8] != 8'h00);
    rd  = two ? cmd[15] : lo[7];
    exp_cmdb = two ? 16 : 8;
    exp_h = (dv == 0) ? 1 : int'(dv);
    ef = two ? {8'h00, cmd[15:8], lo} : {16'h0000, lo};
    nb = exp_cmdb;
    if (!rd) begin
      ef = {ef[15:0], wd};
      nb = nb + 8;
    end
    @(negedge clk);
    mon_clear();
    reply = rep;
    chk(req_ready_o == 1'b1, "R2 ready before request", 32'(req_ready_o), 1);
    req_cmd_i = cmd; req_wdata_i = wd; div_i = dv; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk(ser_en_n_o == 1'b0, "R2 enable low after accept", 32'(ser_en_n_o), 0);
    if (poke) begin
      req_cmd_i = ~cmd; req_wdata_i = ~wd; div_i = 8'd7; req_valid_i = 1'b1;
      repeat (3) begin
        @(negedge clk);
        chk(req_ready_o == 1'b0, "R2 not ready while busy", 32'(req_ready_o), 0);
      end
      req_valid_i = 1'b0;
    end
    guard = 0;
    while (!done_o && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(done_o == 1'b1, "R8 done seen", 32'(done_o), 1);
    chk(ser_en_n_o && ser_dat_oe_o && ser_clk_o, "R8 lines idle at done",
        {29'd0, ser_en_n_o, ser_dat_oe_o, ser_clk_o}, 32'h7);
    chk(ncap == nb, "R5/R6 driven bit count", 32'(ncap), 32'(nb));
    chk(cap == ef, "R3/R4/R5/R6 frame bits", 32'(cap), 32'(ef));
    chk(nrel == (rd ? 8 : 0), "R7 released pulses", 32'(nrel), rd ? 8 : 0);
    chk(badlow == 0, "R9 low half-period length", 32'(badlow), 0);
    chk(leadlen == exp_h, "R9 lead length", 32'(leadlen), 32'(exp_h));
    if (rd) begin
      chk(rdata_o == rep, "R7 read byte", 32'(rdata_o), 32'(rep));
      last_rd = rep;
    end else begin
      chk(rdata_o == last_rd, "R8 rdata kept on write", 32'(rdata_o), 32'(last_rd));
    end
    @(negedge clk);
    chk(done_o == 1'b0, "R8 done single cycle", 32'(done_o), 0);
    if (poke) begin
      repeat (4) @(negedge clk);
      chk(ser_en_n_o == 1'b1, "R2 busy request dropped", 32'(ser_en_n_o), 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] uppers [6];
    logic [7:0] lows [4];
    logic [7:0] divs [3];
    uppers = '{8'h01, 8'h38, 8'h7F, 8'h80, 8'hB8, 8'hFF};
    lows   = '{8'h00, 8'h5E, 8'hA3, 8'hFF};
    divs   = '{8'd0, 8'd2, 8'd3};
    mon_clear();
    exp_cmdb = 8; exp_h = 1; reply = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ser_en_n_o && ser_clk_o && ser_dat_oe_o && req_ready_o && !done_o,
        "R1 lines in reset",
        {27'd0, ser_en_n_o, ser_clk_o, ser_dat_oe_o, req_ready_o, done_o}, 32'h1E);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdata_o == 8'h00, "R1 rdata after reset", 32'(rdata_o), 0);
    chk(req_ready_o == 1'b1, "R1 ready after reset", 32'(req_ready_o), 1);
    // every one-byte command at the shortest half-period
    for (int c = 0; c < 256; c++)
      run_txn({8'h00, 8'(c)}, 8'(c * 37 + 11), 8'(c ^ 8'hA5), 8'd1, (c % 64) == 5);
    // two-byte commands over a spread of upper bytes and dividers
    for (int u = 0; u < 6; u++)
      for (int l = 0; l < 4; l++)
        for (int d = 0; d < 3; d++)
          run_txn({uppers[u], lows[l]}, 8'(u * 50 + l * 7 + d),
                  8'(uppers[u] + lows[l] + 8'(d)), divs[d], (l == 1));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule